// File: doc/BRIEF.md
# Dual-Mode Character Entry Controller

This block loads 6-bit character codes from a processor bus into a small display memory of 8 words. It has two ways of choosing where a code goes. In random mode the processor puts a 3-bit location on the shared control lines. In sequential mode an internal location counter fills the words from left to right. The same three lines then carry an entry enable, an active-low clear and the full indication.

A write is framed by an effective strobe, which is active while both the write line and the chip select are low. The strobe is synchronised to the system clock through two flip-flops and edge-detected. Mode, location and enable are taken when the strobe becomes active. The data word is stored when the strobe ends.

A display-full flag rises once the last location has been filled in sequential mode. It lets several controllers be chained, each taking entries only until it is full. A write-busy output spans each write that will actually change memory, so a display scanner can pause during the write. The scanner reads the memory through its own combinational read port.

Top module: `char_entry_ctrl`

## Requirements
- R1: The effective strobe is active only while `wrN` and `csN` are both low. Toggling one of them while the other stays high changes nothing.
- R2: `modeIn` is latched when the effective strobe becomes active: 1 selects sequential, 0 selects random. The latched mode changes at no other time.
- R3: In random mode, `addrIn[2:0]` is latched when the strobe becomes active. Later changes to `addrIn` during the same write do not change the target word.
- R4: The value on `dataIn` when the strobe ends is written to the selected word. The word then reads back on `scanData` when `scanAddr` selects it.
- R5: In sequential mode, `addrIn[0]` is the entry enable and is latched when the strobe becomes active. A write stores nothing if that enable is 0.
- R6: Each stored sequential write advances the counter by one, starting from word 0. After 8 stored entries the full state is set, and further sequential writes store nothing.
- R7: While sequential mode is latched, `addrIn[1]` low immediately (without a clock edge) empties all 8 words to the blank code 6'b100000, returns the counter to 0 and clears the full state.
- R8: While random mode is latched, `addrIn[1]` low has no clearing effect.
- R9: `dispFull` is high only when the full state is set and sequential mode is latched. The full state is kept across a stay in random mode.
- R10: `wrBusy` rises 3 clock edges after the strobe becomes active and stays high until the write commits, for every random write and for sequential writes that are enabled and not full. It stays low for any other write.
- R11: Synchronous reset `rst` selects random mode, sets the counter to 0, clears full and busy, and blanks all words.
- R12: A stored word appears on `scanData` 3 clock edges after the strobe ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wrN | input | 1 | Write strobe, active low |
| csN | input | 1 | Chip select, active low |
| modeIn | input | 1 | Entry mode: 1 sequential, 0 random |
| addrIn | input | 3 | Random: location. Sequential: bit 0 entry enable, bit 1 clear (active low) |
| dataIn | input | 6 | Character code |
| scanAddr | input | 3 | Scanner read location |
| scanData | output | 6 | Word at `scanAddr` |
| wrBusy | output | 1 | A qualifying write is in progress |
| dispFull | output | 1 | Sequential memory full |

## Verification
On every cycle, the assertions check several rules:
- the latched mode and the latched location move only on a strobe start;
- the counter advances by exactly one per stored sequential write;
- full rises only on such a write;
- busy follows the qualification rule for random writes and for full sequential writes.

Other behaviours can only be shown by the bench's scenarios, because they concern stored contents or events with no clock edge:
- that the data reaches the right word;
- that a write is lost when chip select stays high;
- that the asynchronous clear empties the memory at once in sequential mode but not in random mode;
- that the full state survives a stay in random mode.

// File: rtl/char_entry_pkg.sv
package char_entry_pkg;

  // Strobes from control to datapath for one write transaction
  typedef struct packed {
    logic capture;  // strobe start in random mode: latch location
    logic commit;   // strobe end of a qualifying write: store word
    logic seqSel;   // latched mode is sequential
  } entryStrb_t;

endpackage

// File: rtl/char_entry_ctl.sv
module char_entry_ctl
  import char_entry_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wrN,
  input  logic       csN,
  input  logic       modeIn,
  input  logic       senIn,
  input  logic       fullIn,
  output entryStrb_t strb,
  output logic       seqMode,
  output logic       wrBusy
);

  localparam int LAST = SYNC_STAGES - 1;

  logic                   effStrobe;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lastQ;
  logic                   effRise;
  logic                   effFall;
  logic                   modeQ;
  logic                   busyQ;

  assign effStrobe = ~wrN & ~csN;
  assign effRise   = syncQ[LAST] & ~lastQ;
  assign effFall   = ~syncQ[LAST] & lastQ;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= effStrobe;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '0;
        else     syncQ <= {syncQ[LAST-1:0], effStrobe};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      lastQ <= 1'b0;
      modeQ <= 1'b0;
      busyQ <= 1'b0;
    end else begin
      lastQ <= syncQ[LAST];
      if (effRise) begin
        modeQ <= modeIn;
        busyQ <= modeIn ? (senIn & ~fullIn) : 1'b1;
      end else if (effFall) begin
        busyQ <= 1'b0;
      end
    end
  end

  always_comb begin
    strb.capture = effRise & ~modeIn;
    strb.commit  = effFall & busyQ;
    strb.seqSel  = modeQ;
  end

  assign seqMode = modeQ;
  assign wrBusy  = busyQ;

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    !effRise |=> $stable(modeQ)); // R2

  AST_RANDOM_BUSY: assert property (@(posedge clk) disable iff (rst)
    (effRise && !modeIn) |=> wrBusy); // R10

  AST_FULL_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (effRise && modeIn && fullIn) |=> !wrBusy); // R6

  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (rst)
    effFall |=> !wrBusy); // R10

endmodule

// File: rtl/char_entry_dp.sv
module char_entry_dp
  import char_entry_pkg::*;
#(
  parameter int          ADDR_W = 3,
  parameter int          DATA_W = 6,
  parameter logic [5:0]  BLANK  = 6'b100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clrN,
  input  entryStrb_t        strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [ADDR_W-1:0] scanAddr,
  output logic [DATA_W-1:0] scanData,
  output logic              fullQ
);

  localparam int                DEPTH    = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST_LOC = ADDR_W'(DEPTH - 1);
  localparam logic [DATA_W-1:0] BLANK_W  = DATA_W'(BLANK);

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] cntQ;
  logic [ADDR_W-1:0] target;
  logic [DATA_W-1:0] memQ [DEPTH];

  always_ff @(posedge clk) begin
    if (rst)               addrQ <= '0;
    else if (strb.capture) addrQ <= addrIn;
  end

  assign target = strb.seqSel ? cntQ : addrQ;

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      cntQ  <= '0;
      fullQ <= 1'b0;
    end else if (rst) begin
      cntQ  <= '0;
      fullQ <= 1'b0;
    end else if (strb.commit && strb.seqSel) begin
      cntQ <= cntQ + 1'b1;
      if (cntQ == LAST_LOC) fullQ <= 1'b1;
    end
  end

  generate
    for (genvar w = 0; w < DEPTH; w++) begin : g_word
      always_ff @(posedge clk or negedge clrN) begin
        if (!clrN)                                        memQ[w] <= BLANK_W;
        else if (rst)                                     memQ[w] <= BLANK_W;
        else if (strb.commit && target == ADDR_W'(w))     memQ[w] <= dataIn;
      end
    end
  endgenerate

  assign scanData = memQ[scanAddr];

  AST_LOC_HELD: assert property (@(posedge clk) disable iff (rst)
    !strb.capture |=> $stable(addrQ)); // R3

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst || !clrN)
    (strb.commit && strb.seqSel) |=> cntQ == ADDR_W'($past(cntQ) + 1'b1)); // R6

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst || !clrN)
    !strb.commit |=> $stable(cntQ)); // R6

  AST_FULL_RISE: assert property (@(posedge clk) disable iff (rst || !clrN)
    $rose(fullQ) |-> $past(strb.commit && strb.seqSel)); // R6

endmodule

// File: rtl/char_entry_ctrl.sv
module char_entry_ctrl
  import char_entry_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrN,
  input  logic              csN,
  input  logic              modeIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [ADDR_W-1:0] scanAddr,
  output logic [DATA_W-1:0] scanData,
  output logic              wrBusy,
  output logic              dispFull
);

  entryStrb_t strb;
  logic       seqMode;
  logic       fullQ;
  logic       clrN;

  // clear line acts only while sequential mode is latched
  assign clrN     = ~(seqMode & ~addrIn[1]);
  assign dispFull = seqMode & fullQ;

  char_entry_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .wrN     (wrN),
    .csN     (csN),
    .modeIn  (modeIn),
    .senIn   (addrIn[0]),
    .fullIn  (fullQ),
    .strb    (strb),
    .seqMode (seqMode),
    .wrBusy  (wrBusy)
  );

  char_entry_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .clrN     (clrN),
    .strb     (strb),
    .addrIn   (addrIn),
    .dataIn   (dataIn),
    .scanAddr (scanAddr),
    .scanData (scanData),
    .fullQ    (fullQ)
  );

  AST_FULL_SEQ_ONLY: assert property (@(posedge clk) disable iff (rst)
    !seqMode |-> !dispFull); // R9

endmodule

// File: tb/char_entry_ctrl_bench.sv
module char_entry_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrN = 1'b1;
  logic       csN = 1'b1;
  logic       modeIn = 1'b0;
  logic [2:0] addrIn = 3'b010;
  logic [5:0] dataIn = '0;
  logic [2:0] scanAddr = '0;
  logic [5:0] scanData;
  logic       wrBusy;
  logic       dispFull;

  int checks = 0;
  int errors = 0;
  logic [5:0] model [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  char_entry_ctrl u_char_entry_ctrl (
    .clk(clk), .rst(rst), .wrN(wrN), .csN(csN), .modeIn(modeIn),
    .addrIn(addrIn), .dataIn(dataIn), .scanAddr(scanAddr),
    .scanData(scanData), .wrBusy(wrBusy), .dispFull(dispFull)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkMem(input string req);
    for (int i = 0; i < 8; i++) begin
      scanAddr = 3'(i);
      #1;
      check(req, int'(scanData), int'(model[i]));
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // random-mode write; location bus changed to locAfter once latched
  task automatic raWrite(input logic [2:0] loc, input logic [2:0] locAfter,
                         input logic [5:0] d);
    modeIn = 1'b0; addrIn = loc; csN = 1'b0; wrN = 1'b0;
    waitN(4);
    check("R10 busy random", int'(wrBusy), 1);
    addrIn = locAfter; dataIn = d; wrN = 1'b1;
    waitN(2);
    check("R12 not yet stored", int'(wrBusy), 1);
    waitN(2);
    check("R10 busy ends", int'(wrBusy), 0);
    csN = 1'b1; addrIn = 3'b010;
  endtask

  task automatic seqWrite(input logic sen, input logic [5:0] d, input logic expBusy);
    modeIn = 1'b1; addrIn = {2'b01, sen}; csN = 1'b0; wrN = 1'b0;
    waitN(4);
    check("R10 busy sequential", int'(wrBusy), int'(expBusy));
    dataIn = d; wrN = 1'b1;
    waitN(4);
    csN = 1'b1; addrIn = 3'b010;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 6'b100000;
    waitN(3);
    rst = 1'b0;
    waitN(1);
    // R11 reset state
    check("R11 busy", int'(wrBusy), 0);
    check("R11 full", int'(dispFull), 0);
    checkMem("R11 blank");

    // R3 R4 random sweep, location bus scrambled after latch
    for (int a = 0; a < 8; a++) begin
      model[a] = 6'((a * 7 + 5) & 63);
      raWrite(3'(a), ~3'(a), model[a]);
    end
    checkMem("R4 R3 random contents");

    // R1 write line alone, then chip select alone
    addrIn = 3'b000; dataIn = 6'h3f; wrN = 1'b0; waitN(5);
    check("R1 no busy without cs", int'(wrBusy), 0);
    wrN = 1'b1; waitN(4);
    csN = 1'b0; waitN(5); csN = 1'b1; waitN(4);
    addrIn = 3'b010;
    checkMem("R1 ignored");

    // R8 clear line in random mode
    addrIn = 3'b000; #1;
    checkMem("R8 no clear");
    waitN(2); addrIn = 3'b010;
    checkMem("R8 still intact");

    // R2 R5 enter sequential with enable low: stores nothing
    seqWrite(1'b0, 6'h11, 1'b0);
    checkMem("R5 disabled write");
    check("R9 full low", int'(dispFull), 0);

    // R7 asynchronous clear
    @(negedge clk); #2;
    addrIn = 3'b000; #1;
    for (int i = 0; i < 8; i++) model[i] = 6'b100000;
    checkMem("R7 clear immediate");
    waitN(1); addrIn = 3'b010;

    // R6 fill in order
    for (int i = 0; i < 8; i++) begin
      model[i] = 6'((i * 11 + 3) & 63);
      seqWrite(1'b1, model[i], 1'b1);
      check("R6 R9 full flag", int'(dispFull), (i == 7) ? 1 : 0);
    end
    checkMem("R6 sequential contents");
    seqWrite(1'b1, 6'h2a, 1'b0);
    checkMem("R6 write when full");

    // R2 R9 switch to random: full hidden, write goes by location
    raWrite(3'b010, 3'b101, 6'h15);
    model[2] = 6'h15;
    check("R9 full hidden in random", int'(dispFull), 0);
    checkMem("R2 random after sequential");

    // R9 back to sequential: full state kept
    seqWrite(1'b1, 6'h07, 1'b0);
    check("R9 full kept", int'(dispFull), 1);
    checkMem("R9 no store");
    addrIn = 3'b000; #1;
    check("R7 full cleared", int'(dispFull), 0);
    waitN(1); addrIn = 3'b010;
    for (int i = 0; i < 8; i++) model[i] = 6'b100000;
    seqWrite(1'b1, 6'h09, 1'b1);
    model[0] = 6'h09;
    checkMem("R7 counter restarts");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule